// File: doc/BRIEF.md
# Nibble-Folded CRC-16 Checksum Engine

This block walks a window of byte-wide memory and folds it into a 16-bit check value. A single start pulse hands it a base address, a byte count and an optional write-back target. The engine then reads the bytes in ascending order through a read port whose data returns exactly one cycle after the request. It pulses `done_o` once the value is final.

The update step does not use a lookup table or a bit-serial shift register. It XORs the running value with a 16-bit input word, takes two 4-bit groups of the low byte of that result, and XORs those groups back in at fixed shifted positions. Input words are built big-endian from adjacent bytes and overlap: each step moves the window by one byte. An odd trailing byte gets one extra step with a zero low half.

When write-back is requested, the engine stores the finished value through its write port, most significant byte first, before it signals completion. A typical use checks a 0xF8-byte parameter area that starts at address 0x00 and places the result at 0xFC/0xFD.

Top module: `nfcrc_engine`

## Requirements
- R1: After reset `busy_o`, `done_o`, `rd_en_o` and `wr_en_o` are 0 and `crc_o` reads 0xFFFF.
- R2: Every accepted job starts from 0xFFFF. One step with running value p and word v computes d = p^v, a = d[3:0], b = d[7:4]^a, and produces (p>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), truncated to 16 bits.
- R3: Let n be the count with bit 0 cleared. Step i (0 ≤ i < n) uses word {byte[base+i], byte[base+i+1]}. When the count is non-zero, the engine issues exactly n+1 reads, at addresses base+0 through base+n in ascending order, and addresses wrap modulo 2^AW.
- R4: For an odd count, one final step uses word {byte[base+n], 8'h00}.
- R5: A count of 0 performs no reads and finishes with `crc_o` = 0xFFFF. Without write-back, `done_o` is high in the cycle right after the accepting edge.
- R6: Count the accepting clock edge as edge 0. `done_o` is high for exactly one cycle, the cycle after edge D. D = (count==0 ? 0 : n+2+count[0]) + (write-back ? 2 : 0). `busy_o` is high from the cycle after edge 0 up to and including the done cycle.
- R7: If `wb_en_i` is 1 at acceptance, the engine writes crc[15:8] to `wb_addr_i` and then crc[7:0] to `wb_addr_i`+1 (wrapping) on two consecutive cycles, just before the done cycle. If `wb_en_i` is 0, it performs no write at all.
- R8: The engine ignores `start_i` while `busy_o` is high. The job in progress keeps its inputs, its timing and its result.
- R9: `rd_en_o` and `wr_en_o` are never high in the same cycle, and neither is high while the engine is idle.
- R10: `crc_o` keeps the final value after the done cycle until the next job is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Job request, taken only when idle |
| base_i | input | AW | First byte address of the window |
| count_i | input | CW | Number of bytes in the window |
| wb_en_i | input | 1 | Store the result when the job ends |
| wb_addr_i | input | AW | Address for the result's high byte |
| rd_en_o | output | 1 | Read request |
| rd_addr_o | output | AW | Read address |
| rd_data_i | input | 8 | Read data, valid one cycle after the request |
| wr_en_o | output | 1 | Write strobe |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | 8 | Write data |
| busy_o | output | 1 | A job is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| crc_o | output | 16 | Running / final check value |

## Verification
The hardest case to reach from the ports is a second start request that lands in the middle of a long job. If the engine wrongly accepted it, the second request would change the base, the count and the write-back choice. To create this case, the stimulus raises `start_i` two cycles into a 40-byte job, with a different window and the opposite write-back setting. The model then requires the original timing, read addresses and stored bytes. The stimulus also covers odd tails, windows long enough to wrap the address space, and a write-back target inside the window that was just read. A port memory model in the bench answers every read one cycle late.

// File: rtl/nfcrc_pkg.sv
package nfcrc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUN,
        ST_TAIL,
        ST_WHI,
        ST_WLO,
        ST_DONE
    } nf_state_e;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } nf_word_t;

    localparam logic [15:0] NF_SEED = 16'hFFFF;

    // One fold: two nibble groups of the mixed low byte re-injected at shifts.
    function automatic logic [15:0] nf_step(input logic [15:0] p, input logic [15:0] v);
        logic [15:0] d;
        logic [15:0] a;
        logic [15:0] b;
        d = p ^ v;
        a = {12'h000, d[3:0]};
        b = {12'h000, d[7:4] ^ d[3:0]};
        return (p >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
    endfunction

endpackage

// File: rtl/nfcrc_fold.sv
module nfcrc_fold
    import nfcrc_pkg::*;
(
    input  logic [15:0] prev_i,
    input  nf_word_t    word_i,
    output logic [15:0] next_o
);
    assign next_o = nf_step(prev_i, word_i);
endmodule

// File: rtl/nfcrc_walker.sv
module nfcrc_walker #(
    parameter int AW = 8,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch_i,
    input  logic          active_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] last_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          arr_v_o,
    output logic          arr_first_o,
    output logic          arr_last_o
);
    logic [CW-1:0] idx_q;
    logic [CW-1:0] arr_idx_q;
    logic          arr_v_q;

    assign rd_en_o     = active_i && (idx_q <= last_i);
    assign rd_addr_o   = base_i + AW'(idx_q);
    assign arr_v_o     = arr_v_q;
    assign arr_first_o = (arr_idx_q == '0);
    assign arr_last_o  = (arr_idx_q == last_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= '0;
            arr_idx_q <= '0;
            arr_v_q   <= 1'b0;
        end else if (launch_i) begin
            idx_q   <= '0;
            arr_v_q <= 1'b0;
        end else begin
            arr_v_q   <= rd_en_o;
            arr_idx_q <= idx_q;
            if (rd_en_o) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nfcrc_engine.sv
module nfcrc_engine
    import nfcrc_pkg::*;
#(
    parameter int AW = 8,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] count_i,
    input  logic          wb_en_i,
    input  logic [AW-1:0] wb_addr_i,
    output logic          rd_en_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic [7:0]    rd_data_i,
    output logic          wr_en_o,
    output logic [AW-1:0] wr_addr_o,
    output logic [7:0]    wr_data_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [15:0]   crc_o
);
    nf_state_e     st;
    logic [AW-1:0] base_q;
    logic [AW-1:0] wba_q;
    logic [CW-1:0] last_q;
    logic          odd_q;
    logic          wb_q;
    logic [15:0]   acc;
    logic [7:0]    hold;
    logic [15:0]   acc_nx;
    nf_word_t      fw;
    logic          launch;
    logic          arr_v;
    logic          arr_first;
    logic          arr_last;

    assign launch = (st == ST_IDLE) && start_i;

    nfcrc_walker #(.AW(AW), .CW(CW)) u_walk (
        .clk         (clk),
        .rst         (rst),
        .launch_i    (launch),
        .active_i    (st == ST_RUN),
        .base_i      (base_q),
        .last_i      (last_q),
        .rd_en_o     (rd_en_o),
        .rd_addr_o   (rd_addr_o),
        .arr_v_o     (arr_v),
        .arr_first_o (arr_first),
        .arr_last_o  (arr_last)
    );

    always_comb begin
        fw.hi = hold;
        fw.lo = (st == ST_TAIL) ? 8'h00 : rd_data_i;
    end

    nfcrc_fold u_fold (
        .prev_i (acc),
        .word_i (fw),
        .next_o (acc_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            base_q <= '0;
            wba_q  <= '0;
            last_q <= '0;
            odd_q  <= 1'b0;
            wb_q   <= 1'b0;
            acc    <= NF_SEED;
            hold   <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start_i) begin
                        base_q <= base_i;
                        last_q <= {count_i[CW-1:1], 1'b0};
                        odd_q  <= count_i[0];
                        wb_q   <= wb_en_i;
                        wba_q  <= wb_addr_i;
                        acc    <= NF_SEED;
                        if (count_i == '0) begin
                            st <= wb_en_i ? ST_WHI : ST_DONE;
                        end else begin
                            st <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    if (arr_v) begin
                        hold <= rd_data_i;
                        if (!arr_first) begin
                            acc <= acc_nx;
                        end
                        if (arr_last) begin
                            st <= odd_q ? ST_TAIL : (wb_q ? ST_WHI : ST_DONE);
                        end
                    end
                end
                ST_TAIL: begin
                    acc <= acc_nx;
                    st  <= wb_q ? ST_WHI : ST_DONE;
                end
                ST_WHI:  st <= ST_WLO;
                ST_WLO:  st <= ST_DONE;
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign wr_en_o   = (st == ST_WHI) || (st == ST_WLO);
    assign wr_addr_o = (st == ST_WLO) ? wba_q + 1'b1 : wba_q;
    assign wr_data_o = (st == ST_WLO) ? acc[7:0] : acc[15:8];
    assign busy_o    = (st != ST_IDLE);
    assign done_o    = (st == ST_DONE);
    assign crc_o     = acc;
endmodule

// File: rtl/nfcrc_engine_chk.sv
module nfcrc_engine_chk #(
    parameter int AW = 8,
    parameter int CW = 9
) (
    input logic          clk,
    input logic          rst,
    input logic          start_i,
    input logic [CW-1:0] count_i,
    input logic          wb_en_i,
    input logic          rd_en_o,
    input logic          wr_en_o,
    input logic [AW-1:0] wr_addr_o,
    input logic [7:0]    wr_data_o,
    input logic          busy_o,
    input logic          done_o,
    input logic [15:0]   crc_o
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                                    // R6
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);                                        // R8
    AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);                                       // R6
    AST_PORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rd_en_o && wr_en_o));                                                 // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!rd_en_o && !wr_en_o));                                    // R9
    AST_WB_HIGH_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en_o) |-> (wr_data_o == crc_o[15:8]));                         // R7
    AST_WB_LOW_NEXT: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_en_o) |=> (wr_en_o && wr_addr_o == $past(wr_addr_o) + 1'b1
                            && wr_data_o == crc_o[7:0]));                       // R7
    AST_WB_THEN_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(wr_en_o) |-> done_o);                                             // R7
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && count_i == '0 && !wb_en_i)
            |=> (done_o && crc_o == 16'hFFFF));                                 // R5
endmodule

bind nfcrc_engine nfcrc_engine_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .count_i   (count_i),
    .wb_en_i   (wb_en_i),
    .rd_en_o   (rd_en_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .crc_o     (crc_o)
);

// File: tb/nfcrc_engine_bench.sv
module nfcrc_engine_bench;
    localparam int AW = 8;
    localparam int CW = 9;
    localparam int MSZ = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          start_i;
    logic [AW-1:0] base_i;
    logic [CW-1:0] count_i;
    logic          wb_en_i;
    logic [AW-1:0] wb_addr_i;
    logic          rd_en_o;
    logic [AW-1:0] rd_addr_o;
    logic [7:0]    rd_data_i;
    logic          wr_en_o;
    logic [AW-1:0] wr_addr_o;
    logic [7:0]    wr_data_o;
    logic          busy_o;
    logic          done_o;
    logic [15:0]   crc_o;

    logic [7:0] mem [MSZ];
    int errs = 0;
    int checks = 0;

    always #4 clk = ~clk;

    nfcrc_engine #(.AW(AW), .CW(CW)) u_nfcrc_engine (
        .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .count_i(count_i),
        .wb_en_i(wb_en_i), .wb_addr_i(wb_addr_i), .rd_en_o(rd_en_o), .rd_addr_o(rd_addr_o),
        .rd_data_i(rd_data_i), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
        .wr_data_o(wr_data_o), .busy_o(busy_o), .done_o(done_o), .crc_o(crc_o)
    );

    // Read port model: data one cycle after the request.
    always @(posedge clk) begin
        if (rd_en_o) rd_data_i <= mem[rd_addr_o];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_upd(input logic [15:0] p, input logic [15:0] v);
        int d, lo, mix, r;
        d   = int'(p ^ v);
        lo  = d % 16;
        mix = ((d / 16) % 16) ^ lo;
        r   = (int'(p) / 256) ^ (lo * 8) ^ (lo * 256) ^ mix ^ (mix * 128) ^ (mix * 4096);
        return 16'(r);
    endfunction

    function automatic logic [15:0] ref_crc(input logic [AW-1:0] b, input int cnt);
        logic [15:0] c = 16'hFFFF;
        int n = cnt - (cnt % 2);
        for (int i = 0; i < n; i++) begin
            c = ref_upd(c, {mem[AW'(b + i)], mem[AW'(b + i + 1)]});
        end
        if (cnt % 2 == 1) c = ref_upd(c, {mem[AW'(b + n)], 8'h00});
        return c;
    endfunction

    task automatic run(input logic [AW-1:0] b, input int cnt, input bit wb,
                       input logic [AW-1:0] wa, input bit poke);
        int n = cnt - (cnt % 2);
        int odd = cnt % 2;
        int dd = ((cnt == 0) ? 0 : n + 2 + odd) + (wb ? 2 : 0);
        logic [15:0] exp = ref_crc(b, cnt);
        logic [7:0] keep = mem[wa];
        int rd_seen = 0;
        int wr_seen = 0;
        string sreq = (cnt == 0) ? "R5" : ((odd == 1) ? "R4" : "R2");
        @(negedge clk);
        base_i = b; count_i = CW'(cnt); wb_en_i = wb; wb_addr_i = wa; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k <= dd + 1; k++) begin
            if (k > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            if (poke && k == 2) begin
                // R8: request with another window while busy
                start_i = 1'b1; count_i = CW'(5); base_i = b + 8'd7; wb_en_i = !wb;
            end else begin
                start_i = 1'b0;
            end
            check(done_o == (k == dd), "R6", "done timing", int'(done_o), int'(k == dd));
            check(busy_o == (k <= dd), "R6", "busy window", int'(busy_o), int'(k <= dd));
            if (rd_en_o) begin
                check(rd_addr_o == AW'(b + rd_seen), "R3", "read address",
                      int'(rd_addr_o), int'(AW'(b + rd_seen)));
                rd_seen++;
            end
            if (wr_en_o) begin
                check(wr_addr_o == AW'(wa + wr_seen), "R7", "write address",
                      int'(wr_addr_o), int'(AW'(wa + wr_seen)));
                check(wr_data_o == ((wr_seen == 0) ? exp[15:8] : exp[7:0]), "R7",
                      "write data", int'(wr_data_o),
                      int'((wr_seen == 0) ? exp[15:8] : exp[7:0]));
                mem[wr_addr_o] = wr_data_o;
                wr_seen++;
            end
            if (k == dd) check(crc_o == exp, sreq, "result", int'(crc_o), int'(exp));
        end
        check(rd_seen == ((cnt == 0) ? 0 : n + 1), "R3", "read count", rd_seen,
              (cnt == 0) ? 0 : n + 1);
        check(wr_seen == (wb ? 2 : 0), "R7", "write count", wr_seen, wb ? 2 : 0);
        if (!wb) check(mem[wa] == keep, "R7", "untouched target", int'(mem[wa]), int'(keep));
        check(crc_o == exp, "R10", "held result", int'(crc_o), int'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MSZ; i++) mem[i] = 8'($urandom);
        rst = 1'b1; start_i = 1'b0; base_i = '0; count_i = '0; wb_en_i = 1'b0;
        wb_addr_i = '0; rd_data_i = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !done_o, "R1", "idle after reset", int'({busy_o, done_o}), 0);
        check(!rd_en_o && !wr_en_o, "R1", "ports quiet", int'({rd_en_o, wr_en_o}), 0);
        check(crc_o == 16'hFFFF, "R1", "reset value", int'(crc_o), 16'hFFFF);
        rst = 1'b0;

        run(8'h00, 'hF8, 1'b1, 8'hFC, 1'b0);   // standard area
        run(8'h30, 0, 1'b0, 8'h90, 1'b0);      // R5
        run(8'h30, 0, 1'b1, 8'h90, 1'b0);      // R5 with write-back
        run(8'h11, 1, 1'b0, 8'hA0, 1'b0);      // R4
        run(8'h12, 2, 1'b1, 8'hA0, 1'b0);      // R2
        run(8'h13, 3, 1'b0, 8'hA0, 1'b0);      // R4
        run(8'hF0, 37, 1'b1, 8'hFF, 1'b0);     // R3 wrap, R7 wrap
        run(8'h40, 40, 1'b1, 8'h10, 1'b1);     // R8 busy start
        run(8'h05, 511, 1'b1, 8'h20, 1'b0);    // R3 long wrap, target inside
        for (int t = 0; t < 16; t++) begin
            int c = int'($urandom_range(1, 300));
            if (t % 2 == 0) c = c - (c % 2);
            else c = c | 1;
            run(8'($urandom), c, bit'(t % 3 != 0), 8'($urandom), 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule